// File: doc/BRIEF.md
# Dual-Clock Sequential Line Memory

This block stores one scan line of up to 5120 bytes and replays it in order. The write side and the read side each run on their own clock. Each side has its own address counter. The counter starts from zero when that side's restart pin is pulled low, and it steps by one location each time that side's enable is held low at a clock edge. No handshake or fill-level logic sits between the two sides. A producer writes a line, the consumer restarts its counter and pulls the line out, and the consumer may replay the same line any number of times, because reading never removes data.

The read side registers the fetched byte. Next to the data bus it drives an output-enable flag. The flag is low whenever no read took place on the last read-clock edge, and it stands in for a bus that floats. Both ports use plain level-sampled controls with no back-pressure. A word is accepted or delivered on every edge where the port's enable is low, so each side must be paced by whatever drives it.

Top module: `line_mem_dc`

## Requirements
- R1: When `wr_en_n` is 0 and `wr_rst_n` is 1 at a rising `wr_clk` edge, `wr_data` is stored at the current write address, and the write address advances by one.
- R2: When `wr_en_n` is 1 and `wr_rst_n` is 1 at a rising `wr_clk` edge, nothing is stored and the write address holds. Words written later therefore land on consecutive locations with no holes.
- R3: When `wr_rst_n` is 0 at a rising `wr_clk` edge, the write address becomes 0 and nothing is stored, whatever `wr_en_n` is.
- R4: When `rd_en_n` is 0 and `rd_rst_n` is 1 at a rising `rd_clk` edge, the word at the current read address appears on `rd_data` after that edge, `rd_oe` is 1, and the read address advances by one.
- R5: When `rd_en_n` is 1 at a rising `rd_clk` edge, `rd_oe` is 0 after that edge and the read address holds.
- R6: When `rd_rst_n` is 0 at a rising `rd_clk` edge, the read address becomes 0, `rd_oe` is 0 after that edge, and no read occurs, whatever `rd_en_n` is.
- R7: Both address counters wrap from location 5119 to location 0 when they advance.
- R8: Reading is non-destructive. Reading the same location again returns the same word until it is overwritten.
- R9: While no read occurs, `rd_data` keeps the last word that was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Synchronous write-address restart, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 8 | Word to store |
| rd_clk | input | 1 | Read-side clock, asynchronous to `wr_clk` |
| rd_rst_n | input | 1 | Synchronous read-address restart, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 8 | Registered read word |
| rd_oe | output | 1 | 1 when `rd_data` carries a word fetched on the last read edge |

## Verification
A write is due one `wr_clk` edge after its controls are applied. It can only be seen through the read port, so the bench checks writes through later reads in a separate phase, never at an address being written. A read result, the state of `rd_oe` and the holding of `rd_data` are all due at the first rising `rd_clk` edge after the controls are applied. The bench therefore changes controls on a falling edge, waits for one rising edge, and samples on the following falling edge. The write clock and the read clock have different periods, so the write-side and read-side timing are exercised independently.

// File: rtl/lm_pkg.sv
package lm_pkg;

  parameter int unsigned LM_DEPTH = 5120;
  parameter int unsigned LM_WIDTH = 8;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_ACCESS  = 2'd1,
    OP_RESTART = 2'd2
  } lm_op_e;

  // restart wins over the enable on the same edge
  function automatic lm_op_e lm_decode(input logic rst_n, input logic en_n);
    if (!rst_n)     return OP_RESTART;
    else if (!en_n) return OP_ACCESS;
    else            return OP_IDLE;
  endfunction

  function automatic int unsigned lm_addr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/lm_addr_seq.sv
module lm_addr_seq
  import lm_pkg::*;
#(
  parameter int unsigned DEPTH = LM_DEPTH,
  parameter int unsigned AW    = lm_addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  output logic [AW-1:0] addr_q,
  output lm_op_e        op
);

  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
  localparam bit            POW2    = (DEPTH == (1 << AW));

  logic [AW-1:0] addr_inc;

  assign op = lm_decode(rst_n, en_n);

  generate
    if (POW2) begin : g_roll
      assign addr_inc = addr_q + 1'b1;
    end else begin : g_cmp
      assign addr_inc = (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    case (op)
      OP_RESTART: addr_q <= '0;
      OP_ACCESS:  addr_q <= addr_inc;
      default:    addr_q <= addr_q;
    endcase
  end

  // assertions stay quiet until the first restart has been seen
  logic seen_rst_q = 1'b0;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_rst_q <= 1'b1;
  end

  AST_CTR_RESTART: assert property (@(posedge clk) disable iff (!seen_rst_q)
    !rst_n |=> (addr_q == '0)); // R3, R6
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!seen_rst_q)
    (rst_n && en_n) |=> $stable(addr_q)); // R2, R5
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!seen_rst_q)
    (rst_n && !en_n && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1)); // R1, R4
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!seen_rst_q)
    (rst_n && !en_n && addr_q == LAST) |=> (addr_q == '0)); // R7

endmodule

// File: rtl/lm_store.sv
module lm_store
  import lm_pkg::*;
#(
  parameter int unsigned DEPTH = LM_DEPTH,
  parameter int unsigned WIDTH = LM_WIDTH,
  parameter int unsigned AW    = lm_addr_bits(DEPTH)
) (
  input  logic             wr_clk,
  input  lm_op_e           wr_op,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_word
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_op == OP_ACCESS) mem[wr_addr] <= wr_data;
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/lm_rd_port.sv
module lm_rd_port
  import lm_pkg::*;
#(
  parameter int unsigned WIDTH = LM_WIDTH
) (
  input  logic             clk,
  input  lm_op_e           op,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] data_q,
  output logic             oe_q
);

  always_ff @(posedge clk) begin
    oe_q <= (op == OP_ACCESS);
    if (op == OP_ACCESS) data_q <= word;
  end

endmodule

// File: rtl/line_mem_dc.sv
module line_mem_dc
  import lm_pkg::*;
#(
  parameter int unsigned DEPTH = LM_DEPTH,
  parameter int unsigned WIDTH = LM_WIDTH
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe
);

  localparam int unsigned AW = lm_addr_bits(DEPTH);

  logic [AW-1:0] wr_addr, rd_addr;
  lm_op_e        wr_op, rd_op;
  logic [WIDTH-1:0] rd_word;

  lm_addr_seq #(.DEPTH(DEPTH), .AW(AW)) wr_seq_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .en_n(wr_en_n), .addr_q(wr_addr), .op(wr_op)
  );

  lm_addr_seq #(.DEPTH(DEPTH), .AW(AW)) rd_seq_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .en_n(rd_en_n), .addr_q(rd_addr), .op(rd_op)
  );

  lm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) store_i (
    .wr_clk(wr_clk), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  lm_rd_port #(.WIDTH(WIDTH)) rd_port_i (
    .clk(rd_clk), .op(rd_op), .word(rd_word), .data_q(rd_data), .oe_q(rd_oe)
  );

  logic rd_seen_q = 1'b0;
  always_ff @(posedge rd_clk) begin
    if (!rd_rst_n) rd_seen_q <= 1'b1;
  end

  AST_OE_IDLE: assert property (@(posedge rd_clk) disable iff (!rd_seen_q)
    (rd_rst_n && rd_en_n) |=> !rd_oe); // R5
  AST_OE_RESTART: assert property (@(posedge rd_clk) disable iff (!rd_seen_q)
    !rd_rst_n |=> !rd_oe); // R6
  AST_OE_READ: assert property (@(posedge rd_clk) disable iff (!rd_seen_q)
    (rd_rst_n && !rd_en_n) |=> rd_oe); // R4
  AST_DATA_KEEP: assert property (@(posedge rd_clk) disable iff (!rd_seen_q)
    (!rd_rst_n || rd_en_n) |=> $stable(rd_data)); // R9

endmodule

// File: tb/line_mem_dc_tb_top.sv
module line_mem_dc_tb_top;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DEPTH     = 5120;
  localparam int NVEC      = 12;
  localparam int LIMIT_NS  = 600000;

  // {gap_before, data}: gap inserts one idle write cycle and one idle read cycle
  localparam logic [8:0] VEC [NVEC] = '{
    9'h0_3C, 9'h1_A5, 9'h0_00, 9'h0_FF, 9'h1_81, 9'h1_7E,
    9'h0_12, 9'h1_C3, 9'h0_5A, 9'h0_96, 9'h1_01, 9'h0_E7
  };

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst_n = 1'b1, wr_en_n = 1'b1, rd_rst_n = 1'b1, rd_en_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  line_mem_dc dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // caller stands at a falling wr_clk edge; returns at the next falling edge
  task automatic wr_cycle(input logic en_n, input logic rst_n, input logic [7:0] d);
    wr_en_n = en_n; wr_rst_n = rst_n; wr_data = d;
    @(posedge wr_clk);
    @(negedge wr_clk);
    wr_en_n = 1'b1; wr_rst_n = 1'b1;
  endtask

  // caller stands at a falling rd_clk edge; result is sampled on return
  task automatic rd_cycle(input logic en_n, input logic rst_n);
    rd_en_n = en_n; rd_rst_n = rst_n;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en_n = 1'b1; rd_rst_n = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial begin
    #(LIMIT_NS);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    @(negedge wr_clk);
    wr_cycle(1'b1, 1'b0, 8'h00);
    @(negedge rd_clk);
    rd_cycle(1'b1, 1'b0);
    check("R6 reset state oe", {1'b0, rd_oe}, 9'd0);

    // table phase: write line with gaps (R1, R2)
    @(negedge wr_clk);
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][8]) wr_cycle(1'b1, 1'b1, ~VEC[i][7:0]);
      wr_cycle(1'b0, 1'b1, VEC[i][7:0]);
    end

    // two readback passes with read gaps (R4, R5, R8, R9)
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge rd_clk);
      rd_cycle(1'b1, 1'b0);
      for (int i = 0; i < NVEC; i++) begin
        if (VEC[i][8]) begin
          held = rd_data;
          rd_cycle(1'b1, 1'b1);
          check("R5 oe low on idle", {1'b0, rd_oe}, 9'd0);
          check("R9 data kept on idle", {1'b0, rd_data}, {1'b0, held});
        end
        rd_cycle(1'b0, 1'b1);
        check(pass == 0 ? "R1 R2 R4 line word" : "R8 reread word",
              {rd_oe, rd_data}, {1'b1, VEC[i][7:0]});
      end
    end

    // R3: restart wins over enable, no store
    @(negedge wr_clk);
    wr_cycle(1'b0, 1'b0, 8'hEE);
    wr_cycle(1'b0, 1'b1, 8'h11);
    @(negedge rd_clk);
    rd_cycle(1'b1, 1'b0);
    rd_cycle(1'b0, 1'b1);
    check("R3 restart then addr0", {rd_oe, rd_data}, {1'b1, 8'h11});
    rd_cycle(1'b0, 1'b1);
    check("R3 no store on restart", {rd_oe, rd_data}, {1'b1, VEC[1][7:0]});

    // R6: read restart wins over enable
    rd_cycle(1'b0, 1'b0);
    check("R6 restart oe low", {1'b0, rd_oe}, 9'd0);
    check("R6 no read on restart", {1'b0, rd_data}, {1'b0, VEC[1][7:0]});
    rd_cycle(1'b0, 1'b1);
    check("R6 addr back to 0", {rd_oe, rd_data}, {1'b1, 8'h11});

    // R7: wrap on both counters
    @(negedge wr_clk);
    wr_cycle(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH + 2; i++) wr_cycle(1'b0, 1'b1, pat(i));
    @(negedge rd_clk);
    rd_cycle(1'b1, 1'b0);
    for (int k = 0; k < DEPTH + 2; k++) begin
      int a;
      a = k % DEPTH;
      rd_cycle(1'b0, 1'b1);
      check("R7 wrap word", {rd_oe, rd_data},
            {1'b1, (a < 2) ? pat(a + DEPTH) : pat(a)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule